// File: doc/BRIEF.md
# Signed Compare-Immediate Execution Unit

This unit carries out one integer instruction: a signed comparison of a general register against a 16-bit immediate taken from the instruction word. It decodes the 32-bit instruction and drives a register-file read index from it. It compares the returned 64-bit value with the sign-extended immediate and writes a four-flag record into one selected 4-bit field of the 32-bit condition register. Every other condition-register field passes through unchanged.

An execute stage pulses `in_valid` for one cycle with the instruction, the register value, the sticky summary-overflow bit and the current condition register. On the next clock edge the unit presents the updated condition register, a done strobe and a program-counter step of 4. If the opcode is anything else, the unit flags it as illegal, passes the condition register through untouched and reports a step of 0.

Top module: `cmpi_exec`

## Requirements
- R1: An instruction is recognised only when its top six bits (`insn[31:26]`) equal 11 (word pattern 0x2C000000). For any other value, `out_illegal` is 1 with the done strobe, `cr_out` equals the `cr_in` that was presented, and `pc_step` is 0.
- R2: Instruction bits are numbered with bit 0 as the MSB. The field selector is `insn[25:23]`, the width bit is `insn[21]`, the source index is `insn[20:16]` and is driven on `rf_idx` combinationally, and the immediate is `insn[15:0]`.
- R3: The immediate is always sign-extended to the compare width. For example, 0x8000 means -32768 and 0x7FFF means +32767.
- R4: With the width bit 0, the low 32 bits of the register are sign-extended and compared, and the upper 32 bits have no effect.
- R5: With the width bit 1, all 64 bits of the register are compared as a signed value.
- R6: The written field holds LT in bit 3, GT in bit 2, EQ in bit 1 and SO in bit 0. Exactly one of LT, GT and EQ is set, and it follows the signed relation of the register to the immediate.
- R7: The SO bit of the written field copies `so_in` and does not depend on the compare.
- R8: Field k (0 to 7) occupies condition-register bits 31-4k down to 28-4k. Only the selected field may differ from `cr_in`.
- R9: The relation comes from a direct signed comparison. The most negative 64-bit value against +1 gives LT, and the most positive against -1 gives GT.
- R10: `out_done`, `cr_out`, `out_illegal` and `pc_step` are registered on the edge that accepts `in_valid`. The done strobe lasts one cycle per accepted instruction, and `pc_step` is 4 for a recognised instruction.
- R11: Instruction bit 9 (`insn[22]`) is reserved, and its value has no effect on the result.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle instruction strobe |
| in_ready | output | 1 | Unit out of reset and accepting |
| insn | input | 32 | Instruction word |
| rf_idx | output | 5 | Register-file read index |
| rf_data | input | 64 | Register-file read data |
| so_in | input | 1 | Sticky summary-overflow bit |
| cr_in | input | 32 | Current condition register |
| out_done | output | 1 | Result strobe |
| out_illegal | output | 1 | Opcode did not match |
| cr_out | output | 32 | Updated condition register |
| pc_step | output | 4 | Program-counter increment |

## Verification
The bench targets three groups of corner cases.

- **Width bit.** Register values whose upper word contradicts the lower word are run with the width bit 0, and again with the same values at width bit 1. A unit that ignores the width bit, or that zero-extends the low word, turns an EQ or LT into GT.
- **Extremes.** Immediates 0x8000 and 0x7FFF and registers at the signed limits are run at both widths. These expose zero-extension of the immediate and a relation taken from a wrapped subtraction, which reports GT for the most negative value against +1.
- **Field handling.** All eight field positions are walked, and so are the SO bit, the reserved bit and mismatching opcodes. These catch a reversed field order, a corrupted neighbouring field, an SO computed from the result, and an illegal instruction that still writes.

// File: rtl/cmpi_pkg.sv
package cmpi_pkg;
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned OPC_VAL  = 11;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned NFIELD   = 8;
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned CR_W     = NFIELD * FIELD_W;
  localparam int unsigned STEP_W   = 4;
  localparam int unsigned STEP_VAL = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

  typedef struct packed {
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic             wide;
    logic [IDX_W-1:0] idx;
    logic [IMM_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/cmpi_decode.sv
module cmpi_decode
  import cmpi_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  // Big-endian bit i of the word is insn[INSN_W-1-i].
  localparam int unsigned OPC_HI = INSN_W - 1;
  localparam int unsigned SEL_HI = OPC_HI - OPC_W;
  localparam int unsigned RSV_P  = SEL_HI - SEL_W;
  localparam int unsigned WID_P  = RSV_P - 1;
  localparam int unsigned IDX_HI = WID_P - 1;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc      = insn[OPC_HI -: OPC_W];
    dec.hit  = (opc == OPC_W'(OPC_VAL));
    dec.sel  = insn[SEL_HI -: SEL_W];
    dec.wide = insn[WID_P];
    dec.idx  = insn[IDX_HI -: IDX_W];
    dec.imm  = insn[IMM_W-1:0];
  end
endmodule

// File: rtl/cmpi_relate.sv
module cmpi_relate
  import cmpi_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  logic [IMM_W-1:0]  imm,
  input  logic              wide,
  output logic              lt,
  output logic              gt,
  output logic              eq
);
  localparam int unsigned UP_W  = DATA_W - WORD_W;
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic signed [DATA_W-1:0] lhs;
  logic signed [DATA_W-1:0] rhs;

  always_comb begin
    if (wide) lhs = src;
    else      lhs = {{UP_W{src[WORD_W-1]}}, src[WORD_W-1:0]};
    rhs = {{EXT_W{imm[IMM_W-1]}}, imm};
    // Direct signed relations; no subtraction borrow involved.
    lt = (lhs <  rhs);
    gt = (lhs >  rhs);
    eq = (lhs == rhs);
  end
endmodule

// File: rtl/cmpi_crmerge.sv
module cmpi_crmerge
  import cmpi_pkg::*;
(
  input  logic [CR_W-1:0]  cr_old,
  input  logic [SEL_W-1:0] sel,
  input  crf_t             fld,
  output logic [CR_W-1:0]  cr_new
);
  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    localparam int unsigned HI = CR_W - 1 - k * FIELD_W;
    assign cr_new[HI -: FIELD_W] = (sel == SEL_W'(k)) ? fld : cr_old[HI -: FIELD_W];
  end
endmodule

// File: rtl/cmpi_exec.sv
module cmpi_exec
  import cmpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  output logic [IDX_W-1:0]  rf_idx,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              so_in,
  input  logic [CR_W-1:0]   cr_in,
  output logic              out_done,
  output logic              out_illegal,
  output logic [CR_W-1:0]   cr_out,
  output logic [STEP_W-1:0] pc_step
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // datapath
  dec_t            dec;
  crf_t            fld;
  logic [CR_W-1:0] merged;

  cmpi_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  assign rf_idx = dec.idx;

  cmpi_relate u_rel (
    .src  (rf_data),
    .imm  (dec.imm),
    .wide (dec.wide),
    .lt   (fld.lt),
    .gt   (fld.gt),
    .eq   (fld.eq)
  );
  assign fld.so = so_in;

  cmpi_crmerge u_mrg (
    .cr_old (cr_in),
    .sel    (dec.sel),
    .fld    (fld),
    .cr_new (merged)
  );

  // next-state
  logic              rdy_q, rdy_d;
  logic              take;
  logic              done_q, done_d;
  logic              ill_q, ill_d;
  logic [CR_W-1:0]   cr_q, cr_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              res_en;

  always_comb begin
    rdy_d  = 1'b1;
    take   = in_valid & rdy_q;
    done_d = take;
    res_en = take;
    ill_d  = ~dec.hit;
    cr_d   = dec.hit ? merged : cr_in;
    step_d = dec.hit ? STEP_W'(STEP_VAL) : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      cr_q   <= '0;
      step_q <= '0;
    end else begin
      rdy_q  <= rdy_d;
      done_q <= done_d;
      if (res_en) begin
        ill_q  <= ill_d;
        cr_q   <= cr_d;
        step_q <= step_d;
      end
    end
  end

  assign in_ready    = rdy_q;
  assign out_done    = done_q;
  assign out_illegal = done_q & ill_q;
  assign cr_out      = cr_q;
  assign pc_step     = done_q ? step_q : '0;
endmodule

// File: rtl/cmpi_exec_chk.sv
module cmpi_exec_chk
  import cmpi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              take,
  input logic [INSN_W-1:0] insn,
  input logic [CR_W-1:0]   cr_in,
  input logic              so_in,
  input logic [CR_W-1:0]   cr_out,
  input logic              done,
  input logic              illegal,
  input logic [STEP_W-1:0] pc_step
);
  logic [INSN_W-1:0] w_q;
  logic [CR_W-1:0]   c_q;
  logic              s_q;

  always_ff @(posedge clk) begin
    if (take) begin
      w_q <= insn;
      c_q <= cr_in;
      s_q <= so_in;
    end
  end

  logic [SEL_W-1:0]   sel_q;
  logic [CR_W-1:0]    mask;
  logic [FIELD_W-1:0] fout;
  logic               opc_ok;

  always_comb begin
    sel_q  = w_q[INSN_W-1-OPC_W -: SEL_W];
    mask   = {{(CR_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << (CR_W - FIELD_W - FIELD_W * sel_q);
    fout   = FIELD_W'(cr_out >> (CR_W - FIELD_W - FIELD_W * sel_q));
    opc_ok = (w_q[INSN_W-1 -: OPC_W] == OPC_W'(OPC_VAL));
  end

  // R10
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n) take |=> done);
  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !take |=> !done);
  // R1
  illegal_match_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (illegal == !opc_ok));
  // R1
  illegal_keeps_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> (cr_out == c_q) && (pc_step == '0));
  // R6
  one_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal |-> $countones(fout[3:1]) == 1);
  // R7
  so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n) done && !illegal |-> fout[0] == s_q);
  // R8
  other_fields_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> ((cr_out ^ c_q) & ~mask) == '0);
  // R10
  step_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal |-> pc_step == STEP_W'(STEP_VAL));
endmodule

bind cmpi_exec cmpi_exec_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .take    (take),
  .insn    (insn),
  .cr_in   (cr_in),
  .so_in   (so_in),
  .cr_out  (cr_out),
  .done    (out_done),
  .illegal (out_illegal),
  .pc_step (pc_step)
);

// File: tb/cmpi_exec_test.sv
`timescale 1ns/1ps
module cmpi_exec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] insn;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;
  logic        so_in;
  logic [31:0] cr_in;
  logic        out_done;
  logic        out_illegal;
  logic [31:0] cr_out;
  logic [3:0]  pc_step;

  always #2 clk = ~clk;

  cmpi_exec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .rf_idx(rf_idx), .rf_data(rf_data), .so_in(so_in),
    .cr_in(cr_in), .out_done(out_done), .out_illegal(out_illegal),
    .cr_out(cr_out), .pc_step(pc_step)
  );

  typedef struct {
    logic [31:0] cr;
    logic        ill;
    logic [3:0]  step;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   ended = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int sel, input bit rsv,
                                     input bit wide, input int ra, input logic [15:0] imm);
    return {opc[5:0], sel[2:0], rsv, wide, ra[4:0], imm};
  endfunction

  // Reference built from the requirements
  function automatic exp_t model(input logic [31:0] w, input logic [63:0] g,
                                 input bit so, input logic [31:0] cr, input string tag);
    exp_t   e;
    longint a, b;
    int     pos;
    e.tag = tag;
    if (w[31:26] != 6'd11) begin
      e.cr = cr; e.ill = 1'b1; e.step = 4'd0;       // R1
      return e;
    end
    a   = w[21] ? longint'(g) : longint'(int'(g[31:0])); // R4 R5
    b   = longint'(shortint'(w[15:0]));             // R3
    pos = 28 - 4 * int'(w[25:23]);                  // R8
    e.cr = cr;
    e.cr[pos +: 4] = {a < b, a > b, a == b, so};    // R6 R7
    e.ill = 1'b0;
    e.step = 4'd4;
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input logic [63:0] g, input bit so,
                      input logic [31:0] cr, input string tag);
    @(negedge clk);
    insn = w; rf_data = g; so_in = so; cr_in = cr; in_valid = 1'b1;
    exp_q.push_back(model(w, g, so, cr, tag));
    #1;
    chk(rf_idx == w[20:16], "R2 rf_idx", 64'(rf_idx), 64'(w[20:16]));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 64'(out_done), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cr_out == e.cr, {e.tag, " cr"}, 64'(cr_out), 64'(e.cr));
        chk(out_illegal == e.ill, {e.tag, " illegal"}, 64'(out_illegal), 64'(e.ill));
        chk(pc_step == e.step, {e.tag, " step"}, 64'(pc_step), 64'(e.step));
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; rf_data = '0; so_in = 1'b0; cr_in = '0;
    repeat (3) @(negedge clk);
    chk(out_done == 1'b0, "R10 reset done", 64'(out_done), 64'd0);
    chk(out_illegal == 1'b0, "R10 reset illegal", 64'(out_illegal), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 64'd1);
    chk(out_done == 1'b0, "R10 idle", 64'(out_done), 64'd0);

    // R4 narrow equal, upper word ignored
    send(mk(11, 0, 0, 0, 3, 16'h0005), 64'h0000_0000_0000_0005, 0, 32'h0, "R4 eq");
    send(mk(11, 1, 0, 0, 7, 16'h0001), 64'h1234_5678_0000_0001, 0, 32'hFFFF_FFFF, "R4 upper differs eq");
    send(mk(11, 2, 0, 0, 9, 16'h0000), 64'h0000_0000_8000_0000, 0, 32'h0, "R4 low word negative LT");
    send(mk(11, 2, 0, 1, 9, 16'h0000), 64'h0000_0000_8000_0000, 0, 32'h0, "R5 wide same value GT");
    send(mk(11, 3, 0, 0, 4, 16'h0000), 64'hFFFF_FFFF_0000_0000, 0, 32'h0, "R4 upper ones EQ");
    send(mk(11, 3, 0, 1, 4, 16'h0000), 64'hFFFF_FFFF_0000_0000, 0, 32'h0, "R5 upper ones LT");
    // R3 immediate extremes
    send(mk(11, 4, 0, 0, 1, 16'h8000), 64'h0000_0000_FFFF_8000, 0, 32'h0, "R3 0x8000 eq narrow");
    send(mk(11, 4, 0, 0, 1, 16'h8000), 64'h0, 0, 32'h0, "R3 0x8000 GT narrow");
    send(mk(11, 5, 0, 1, 2, 16'h8000), 64'hFFFF_FFFF_FFFF_8000, 0, 32'h0, "R3 0x8000 eq wide");
    send(mk(11, 5, 0, 1, 2, 16'h7FFF), 64'h0000_0000_0000_7FFF, 0, 32'h0, "R3 0x7FFF eq wide");
    send(mk(11, 6, 0, 1, 2, 16'h7FFF), 64'h0000_0000_0000_8000, 0, 32'h0, "R3 0x7FFF GT wide");
    send(mk(11, 6, 0, 0, 2, 16'h7FFF), 64'h0000_0000_0000_7FFE, 0, 32'h0, "R3 0x7FFF LT narrow");
    // R9 boundary values
    send(mk(11, 7, 0, 1, 31, 16'h0001), 64'h8000_0000_0000_0000, 0, 32'h0, "R9 min64 vs 1 LT");
    send(mk(11, 7, 0, 1, 31, 16'hFFFF), 64'h7FFF_FFFF_FFFF_FFFF, 0, 32'h0, "R9 max64 vs -1 GT");
    send(mk(11, 0, 0, 0, 30, 16'h0001), 64'h0000_0000_8000_0000, 0, 32'h0, "R9 min32 vs 1 LT");
    send(mk(11, 0, 0, 0, 30, 16'hFFFF), 64'h0000_0000_7FFF_FFFF, 0, 32'h0, "R9 max32 vs -1 GT");
    // R8 R6 R7 every field, SO copied
    for (int k = 0; k < 8; k++) begin
      send(mk(11, k, 0, k[0], k, 16'h0010), 64'(k * 8), k[1], 32'hA5C3_5A3C, "R8 R7 field walk");
    end
    send(mk(11, 1, 0, 0, 5, 16'h0000), 64'h0, 1, 32'h0, "R7 so set with EQ");
    // R11 reserved bit ignored
    send(mk(11, 3, 1, 0, 6, 16'hFFFE), 64'h0000_0000_FFFF_FFFF, 0, 32'h1111_1111, "R11 reserved set");
    send(mk(11, 3, 1, 1, 6, 16'hFFFE), 64'h0000_0000_FFFF_FFFF, 1, 32'h1111_1111, "R11 reserved set wide");
    // R1 other opcodes
    send(mk(10, 2, 0, 0, 1, 16'h0000), 64'h0, 1, 32'hDEAD_BEEF, "R1 opcode 10");
    send(mk(12, 5, 0, 1, 1, 16'h0000), 64'h5, 0, 32'h0123_4567, "R1 opcode 12");
    send(mk(43, 0, 0, 0, 1, 16'h0000), 64'h0, 0, 32'h89AB_CDEF, "R1 opcode 43");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results seen", 64'(exp_q.size()), 64'd0);
    chk(out_done == 1'b0, "R10 done is a pulse", 64'(out_done), 64'd0);
    finish_run();
  end
endmodule